// File: doc/BRIEF.md
# Branch and Set-Less-Than Compare Unit

This block evaluates the conditional half of a small load/store RISC instruction subset. It takes two register operands, a short immediate and an operation select, and reports whether an equality branch is taken, whether an unconditional jump is taken, and the one-bit result of a less-than compare. That compare comes in signed and unsigned forms, each with a register or an immediate second operand. The block is purely combinational and is meant to sit between operand fetch and the program-counter and writeback muxes. Target address arithmetic, raw opcode decode and register writeback belong to its neighbours.

There is no less-than or greater-or-equal branch. Software builds such a condition from a set-less-than result followed by an equality branch of that result against zero. The less-than core has two forms, chosen by a parameter. One derives both orderings from a single subtraction: signed from the difference sign corrected by overflow, unsigned from the borrow. The other uses the native relational operators.

Top module: `branch_cmp_unit`

## Requirements
- R1: With `op_sel` = 1 (equal branch), `branch_taken` is 1 exactly when `opnd_a` equals `opnd_b`, and `jump_taken` is 0.
- R2: With `op_sel` = 2 (not-equal branch), `branch_taken` is 1 exactly when `opnd_a` differs from `opnd_b`, and `jump_taken` is 0.
- R3: With `op_sel` = 3 (jump), `jump_taken` is 1 and `branch_taken` is 0 for every operand value.
- R4: With `op_sel` = 4 (signed set), `set_result` bit 0 is 1 exactly when `opnd_a` is less than `opnd_b`, both read as two's complement.
- R5: With `op_sel` = 5 (unsigned set), `set_result` bit 0 is 1 exactly when `opnd_a` is less than `opnd_b`, both read as unsigned magnitudes.
- R6: With `op_sel` = 6 (signed immediate set) or 7 (unsigned immediate set), the second operand is `imm_val` sign-extended from IMM_W bits to DATA_W bits, for the unsigned form as well, and `opnd_b` has no effect on any output.
- R7: `set_result` bits DATA_W-1:1 are always 0, and the whole of `set_result` is 0 for every select other than 4 to 7.
- R8: `branch_taken` and `jump_taken` are both 0 for every select that is not 1, 2 or 3, including the unassigned codes 0 and 8 to 15.
- R9: With `opnd_a` all ones and the second operand equal to 1, the signed set gives 1 and the unsigned set gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select, codes as in the requirements |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second register operand |
| imm_val | input | IMM_W | Immediate for the immediate set forms |
| branch_taken | output | 1 | Equality branch condition holds |
| jump_taken | output | 1 | Unconditional jump selected |
| set_result | output | DATA_W | Zero-extended less-than result |

## Verification
An 8-bit copy of the unit is driven with every pair of operand values under each register-form select. This covers every sign combination, so a signed compare is told apart from an unsigned one wherever the two operands' top bits differ, and a wrong overflow correction shows up at each wrap point. The immediate forms are swept over every 4-bit immediate against every 8-bit first operand, with `opnd_b` held at a value that would change the answer. That separates sign extension from zero extension and catches any leak of `opnd_b` into the result. A 32-bit copy is then given directed boundary pairs: all ones against one, the most negative against the most positive value, equal operands and operands differing only in the top bit. The unassigned select codes are applied to both copies.

// File: rtl/branch_cmp_pkg.sv
package branch_cmp_pkg;

   localparam int unsigned SEL_W = 4;

   typedef enum logic [SEL_W-1:0] {
      SEL_NOP   = 4'd0,
      SEL_BEQ   = 4'd1,
      SEL_BNE   = 4'd2,
      SEL_JMP   = 4'd3,
      SEL_SLT   = 4'd4,
      SEL_SLTU  = 4'd5,
      SEL_SLTI  = 4'd6,
      SEL_SLTIU = 4'd7
   } cmp_sel_e;

   typedef struct packed {
      logic br_eq;
      logic br_ne;
      logic jmp;
      logic set_any;
      logic set_signed;
      logic use_imm;
   } cmp_ctl_t;

endpackage

// File: rtl/bcu_sel_decode.sv
module bcu_sel_decode
   import branch_cmp_pkg::*;
(
   input  logic [SEL_W-1:0] sel,
   output cmp_ctl_t         ctl
);
   always_comb begin
      ctl = '0;
      unique case (sel)
         SEL_BEQ:   ctl.br_eq = 1'b1;
         SEL_BNE:   ctl.br_ne = 1'b1;
         SEL_JMP:   ctl.jmp   = 1'b1;
         SEL_SLT: begin
            ctl.set_any    = 1'b1;
            ctl.set_signed = 1'b1;
         end
         SEL_SLTU:  ctl.set_any = 1'b1;
         SEL_SLTI: begin
            ctl.set_any    = 1'b1;
            ctl.set_signed = 1'b1;
            ctl.use_imm    = 1'b1;
         end
         SEL_SLTIU: begin
            ctl.set_any = 1'b1;
            ctl.use_imm = 1'b1;
         end
         default:   ctl = '0;
      endcase
   end
endmodule

// File: rtl/bcu_operand_sel.sv
module bcu_operand_sel #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 16
) (
   input  logic [DATA_W-1:0] reg_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   output logic [DATA_W-1:0] opnd_eff
);
   localparam int unsigned PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (PAD_W == 0) begin : g_no_pad
         assign imm_ext = imm;
      end else begin : g_pad
         assign imm_ext = {{PAD_W{imm[IMM_W-1]}}, imm};
      end
   endgenerate

   assign opnd_eff = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/bcu_eq_detect.sv
module bcu_eq_detect #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned GROUP_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              equal
);
   localparam int unsigned N_GRP = (DATA_W + GROUP_W - 1) / GROUP_W;
   localparam int unsigned PAD_W = N_GRP * GROUP_W;

   logic [PAD_W-1:0] diff_bits;
   logic [N_GRP-1:0] grp_diff;

   generate
      if (PAD_W == DATA_W) begin : g_exact
         assign diff_bits = a ^ b;
      end else begin : g_fill
         assign diff_bits = {{(PAD_W-DATA_W){1'b0}}, a ^ b};
      end
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         assign grp_diff[g] = |diff_bits[g*GROUP_W +: GROUP_W];
      end
   endgenerate

   assign equal = ~|grp_diff;
endmodule

// File: rtl/bcu_lt_core.sv
module bcu_lt_core #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned LT_IMPL = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              lt_signed,
   output logic              lt_unsigned
);
   generate
      if (LT_IMPL == 0) begin : g_sub
         logic [DATA_W:0]   sum;
         logic              ovf;
         assign sum = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
         assign ovf = (a[DATA_W-1] ^ b[DATA_W-1]) & (sum[DATA_W-1] ^ a[DATA_W-1]);
         assign lt_signed   = sum[DATA_W-1] ^ ovf;
         assign lt_unsigned = ~sum[DATA_W];
      end else begin : g_rel
         assign lt_signed   = $signed(a) < $signed(b);
         assign lt_unsigned = a < b;
      end
   endgenerate
endmodule

// File: rtl/branch_cmp_unit.sv
module branch_cmp_unit
   import branch_cmp_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IMM_W   = 16,
   parameter int unsigned GROUP_W = 8,
   parameter int unsigned LT_IMPL = 0
) (
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [IMM_W-1:0]  imm_val,
   output logic              branch_taken,
   output logic              jump_taken,
   output logic [DATA_W-1:0] set_result
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("IMM_W must lie between 1 and DATA_W");
      end
      if (LT_IMPL > 1) begin : g_bad_impl
         $error("LT_IMPL must be 0 or 1");
      end
      if (GROUP_W < 1) begin : g_bad_grp
         $error("GROUP_W must be at least 1");
      end
   endgenerate

   cmp_ctl_t          ctl;
   logic [DATA_W-1:0] opnd_eff;
   logic              is_equal;
   logic              lt_s;
   logic              lt_u;
   logic              set_bit;

   bcu_sel_decode u_dec (
      .sel (op_sel),
      .ctl (ctl)
   );

   bcu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
      .reg_b    (opnd_b),
      .imm      (imm_val),
      .use_imm  (ctl.use_imm),
      .opnd_eff (opnd_eff)
   );

   bcu_eq_detect #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) u_eq (
      .a     (opnd_a),
      .b     (opnd_eff),
      .equal (is_equal)
   );

   bcu_lt_core #(.DATA_W(DATA_W), .LT_IMPL(LT_IMPL)) u_lt (
      .a           (opnd_a),
      .b           (opnd_eff),
      .lt_signed   (lt_s),
      .lt_unsigned (lt_u)
   );

   assign set_bit      = ctl.set_any & (ctl.set_signed ? lt_s : lt_u);
   assign branch_taken = (ctl.br_eq & is_equal) | (ctl.br_ne & ~is_equal);
   assign jump_taken   = ctl.jmp;
   assign set_result   = {{(DATA_W-1){1'b0}}, set_bit};
endmodule

// File: rtl/branch_cmp_chk.sv
module branch_cmp_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 16
) (
   input logic [3:0]        op_sel,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [IMM_W-1:0]  imm_val,
   input logic              branch_taken,
   input logic              jump_taken,
   input logic [DATA_W-1:0] set_result
);
   always_comb begin
      // R1
      beq_taken_chk: assert (op_sel != 4'd1 || (branch_taken == (opnd_a == opnd_b) && !jump_taken));
      // R2
      bne_taken_chk: assert (op_sel != 4'd2 || (branch_taken == (opnd_a != opnd_b) && !jump_taken));
      // R3
      jump_always_chk: assert (op_sel != 4'd3 || (jump_taken && !branch_taken));
      // R7
      set_upper_zero_chk: assert (set_result[DATA_W-1:1] == '0);
      // R7
      set_idle_zero_chk: assert (op_sel inside {4'd4, 4'd5, 4'd6, 4'd7} || set_result == '0);
      // R8
      ctl_quiet_chk: assert (op_sel inside {4'd1, 4'd2, 4'd3} || (!branch_taken && !jump_taken));
      // R9
      boundary_pair_chk: assert (!(opnd_a == '1 && opnd_b == DATA_W'(1))
                                 || (op_sel != 4'd4 || set_result[0])
                                 && (op_sel != 4'd5 || !set_result[0]));
   end
endmodule

bind branch_cmp_unit branch_cmp_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
   .op_sel       (op_sel),
   .opnd_a       (opnd_a),
   .opnd_b       (opnd_b),
   .imm_val      (imm_val),
   .branch_taken (branch_taken),
   .jump_taken   (jump_taken),
   .set_result   (set_result)
);

// File: tb/branch_cmp_unit_test.sv
module branch_cmp_unit_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   int cycles   = 0;
   logic finished = 1'b0;

   // small copy, driven exhaustively
   logic [3:0] s_op;
   logic [7:0] s_a, s_b;
   logic [3:0] s_imm;
   logic       s_br, s_jp;
   logic [7:0] s_set;

   branch_cmp_unit #(.DATA_W(8), .IMM_W(4), .GROUP_W(3)) uut (
      .op_sel(s_op), .opnd_a(s_a), .opnd_b(s_b), .imm_val(s_imm),
      .branch_taken(s_br), .jump_taken(s_jp), .set_result(s_set)
   );

   // full-width copy for boundary pairs
   logic [3:0]  w_op;
   logic [31:0] w_a, w_b;
   logic [15:0] w_imm;
   logic        w_br, w_jp;
   logic [31:0] w_set;

   branch_cmp_unit uut_w (
      .op_sel(w_op), .opnd_a(w_a), .opnd_b(w_b), .imm_val(w_imm),
      .branch_taken(w_br), .jump_taken(w_jp), .set_result(w_set)
   );

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6, 4'd7: return "R6";
         default: return "R8";
      endcase
   endfunction

   // expected outputs from signed / unsigned arithmetic on longint
   task automatic expect_out(input logic [3:0] op, input longint sa, input longint sb,
                             input longint ua, input longint ub,
                             output logic eb, output logic ej, output longint es);
      eb = 1'b0; ej = 1'b0; es = 0;
      case (op)
         4'd1: eb = (ua == ub);
         4'd2: eb = (ua != ub);
         4'd3: ej = 1'b1;
         4'd4, 4'd6: es = (sa < sb) ? 1 : 0;
         4'd5, 4'd7: es = (ua < ub) ? 1 : 0;
         default: ;
      endcase
   endtask

   task automatic check_small(input logic [3:0] op, input int a, input int b, input int imm,
                              input string why);
      longint sa, sb, ua, ub, es;
      logic eb, ej;
      s_op = op; s_a = 8'(a); s_b = 8'(b); s_imm = 4'(imm);
      #2;
      ua = a; sa = (a >= 128) ? a - 256 : a;
      if (op == 4'd6 || op == 4'd7) begin
         sb = (imm >= 8) ? imm - 16 : imm;
         ub = sb & 255;
      end else begin
         ub = b; sb = (b >= 128) ? b - 256 : b;
      end
      expect_out(op, sa, sb, ua, ub, eb, ej, es);
      n_checks++;
      if (s_br !== eb || s_jp !== ej || longint'(s_set) != es) begin
         n_errors++;
         $display("FAIL %s %s op=%0d a=%0d b=%0d imm=%0d: got br=%b jp=%b set=%0d, expected br=%b jp=%b set=%0d",
                  why, tag_of(op), op, a, b, imm, s_br, s_jp, s_set, eb, ej, es);
      end
   endtask

   task automatic check_wide(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] imm, input string why);
      longint sa, sb, ua, ub, es;
      logic eb, ej;
      w_op = op; w_a = a; w_b = b; w_imm = imm;
      #2;
      ua = longint'(a); sa = a[31] ? ua - 64'sd4294967296 : ua;
      if (op == 4'd6 || op == 4'd7) begin
         sb = imm[15] ? longint'(imm) - 65536 : longint'(imm);
         ub = sb & 64'hFFFF_FFFF;
      end else begin
         ub = longint'(b); sb = b[31] ? ub - 64'sd4294967296 : ub;
      end
      expect_out(op, sa, sb, ua, ub, eb, ej, es);
      n_checks++;
      if (w_br !== eb || w_jp !== ej || longint'(w_set) != es) begin
         n_errors++;
         $display("FAIL %s %s op=%0d a=%h b=%h imm=%h: got br=%b jp=%b set=%h, expected br=%b jp=%b set=%0d",
                  why, tag_of(op), op, a, b, imm, w_br, w_jp, w_set, eb, ej, es);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] reg_ops [6];
      reg_ops = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5};
      s_op = 4'd0; s_a = '0; s_b = '0; s_imm = '0;
      w_op = 4'd0; w_a = '0; w_b = '0; w_imm = '0;
      #25 rst = 1'b0;
      #1;

      // idle state after reset: no branch, no jump, zero set (R8, R7)
      check_small(4'd0, 0, 0, 0, "idle R7");
      check_wide(4'd0, 32'h0, 32'h0, 16'h0, "idle R7");

      // every register-form select over every operand pair (R1 R2 R3 R4 R5 R7 R8)
      for (int oi = 0; oi < 6; oi++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
               check_small(reg_ops[oi], a, b, (a + b) & 15, "sweep");

      // immediate forms; opnd_b set to a value that would flip the answer (R6)
      for (int op = 6; op < 8; op++)
         for (int a = 0; a < 256; a++)
            for (int imm = 0; imm < 16; imm++)
               check_small(4'(op), a, (a == 0) ? 255 : 0, imm, "imm R6");

      // unassigned codes quiet on all outputs (R8, R7)
      for (int op = 8; op < 16; op++)
         for (int a = 0; a < 256; a += 17)
            check_small(4'(op), a, a, a & 15, "unassigned R8");

      // full-width boundary pairs (R9, R4, R5, R1, R2)
      check_wide(4'd4, 32'hFFFF_FFFF, 32'h1, 16'h0, "R9 signed");
      check_wide(4'd5, 32'hFFFF_FFFF, 32'h1, 16'h0, "R9 unsigned");
      check_wide(4'd6, 32'hFFFF_FFFF, 32'h0, 16'h0001, "R9 imm signed");
      check_wide(4'd7, 32'hFFFF_FFFF, 32'h0, 16'h0001, "R9 imm unsigned");
      check_wide(4'd4, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, "R4 extremes");
      check_wide(4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, "R4 extremes");
      check_wide(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, "R5 extremes");
      check_wide(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, "R5 extremes");
      check_wide(4'd1, 32'h8000_0000, 32'h0000_0000, 16'h0, "R1 top bit");
      check_wide(4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, "R1 equal");
      check_wide(4'd2, 32'h8000_0000, 32'h0000_0000, 16'h0, "R2 top bit");
      check_wide(4'd2, 32'h1234_5678, 32'h1234_5678, 16'h0, "R2 equal");
      check_wide(4'd3, 32'h0, 32'h1, 16'h0, "R3 jump");
      check_wide(4'd7, 32'hFFFF_7FFF, 32'h0, 16'h8000, "R6 unsigned sign ext");
      check_wide(4'd7, 32'h0000_FFFF, 32'hFFFF_FFFF, 16'h8000, "R6 unsigned sign ext");
      check_wide(4'd6, 32'h0000_0005, 32'h0, 16'h0006, "R6 signed");
      check_wide(4'd6, 32'h0000_0005, 32'hFFFF_FFFF, 16'hFFFF, "R6 opnd_b ignored");
      for (int op = 8; op < 16; op++)
         check_wide(4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, "R8 wide");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule